// File: doc/BRIEF.md
# Self-Clearing Soft Reset Controller

This block holds the software reset request register of a USB controller core that runs in two clock domains: a system bus clock and a PHY clock. Software writes one of two request bits. The light request resets only the bus-clock-domain state machines and their control bits. The heavy request resets both domains, clears the interrupt status and most configuration, and flushes every FIFO. Each bit stays set while its reset is in progress. The block clears it once every affected domain has reported back. Software polls the bit and then knows the core is usable again.

Before any reset strobe is issued, the block holds the bus master off and waits until the master reports no transfer in flight. This lets a transfer that has started finish its data phase cleanly. A heavy request aborts USB-side activity at once. It also sends a level request into the PHY domain through a synchronizer, and the PHY side answers through a second synchronizer. A PHY-ready output marks when the PHY domain may be touched again after a heavy reset. The state machines, FIFOs and bus protocol that get reset are outside this block. Simple strobe and acknowledge ports stand in for them. The configuration register and the sticky interrupt status are modelled inside the block, so that the selective clearing can be seen at the ports.

Top module: `usb_swrst_ctrl`

## Requirements
- R1: After reset, reg_rdata bit 0 (heavy request) and bit 1 (light request) read 0, and bits 30..2 always read 0. A write with reg_wdata bit 0 set makes bit 0 read 1 from the next cycle. A write with only bit 1 set makes bit 1 read 1.
- R2: reg_rdata bit 31 reads 1 exactly when mst_busy is low (the bus master is idle).
- R3: From the cycle after a request is accepted, mst_stop is high. bus_sm_rst stays low while mst_busy is high. bus_sm_rst rises in the cycle after the first clock edge at which mst_busy is sampled low.
- R4: A light reset clears cfg_q bits 11..4 (bus-domain control bits 7..4, interrupt mask bits 11..8). It keeps bits 15..12 and 3..0. It never pulses fifo_flush. It leaves int_stat unchanged, and int_evt pulses that arrive during the reset are still captured.
- R5: A heavy reset clears cfg_q except bits 1..0 (PHY low/full-speed clock select) and bits 3..2 (device speed). It clears int_stat to 0, and it pulses fifo_flush high for exactly one cycle.
- R6: usb_abort is high from the cycle after a heavy request is accepted, even while mst_busy is still high, until the heavy bit clears.
- R7: During a heavy reset, phy_sm_rst is asserted in the PHY domain. Bit 0 stays 1 until both bus_sm_ack and phy_sm_ack have been seen. phy_sm_rst falls only after bit 0 has cleared.
- R8: A light request accepted at edge E with mst_busy low still reads 1 after edge E+2. With bus_sm_ack answering one cycle after bus_sm_rst, it reads 0 after edge E+3.
- R9: phy_ready is 1 after reset and 0 while phy_sm_rst is high. It returns to 1 on the third phy_clk edge after phy_sm_rst falls.
- R10: A write that sets a request bit while a reset is in progress has no effect. No bit is set, no abort is raised, and no further reset follows.
- R11: A write with both bits 0 and 1 set starts only a heavy reset: bit 0 reads 1 and bit 1 reads 0.
- R12: A cfg_wr_en write loads cfg_q at the next edge. An int_evt bit sets the matching int_stat bit, and that bit holds until a heavy reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | System bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| phy_clk | input | 1 | PHY clock |
| phy_rst_n | input | 1 | Synchronous active-low reset, PHY domain |
| reg_wr_en | input | 1 | Write strobe for the reset request register |
| reg_wdata | input | 2 | Request write data: bit 0 heavy, bit 1 light |
| reg_rdata | output | 32 | Register read value: bit 31 master idle, bit 1 light, bit 0 heavy |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_q | output | 16 | Configuration register contents |
| int_evt | input | 4 | Interrupt event pulses |
| int_stat | output | 4 | Sticky interrupt status |
| mst_busy | input | 1 | Bus master has a transfer in flight |
| mst_stop | output | 1 | Hold the bus master off new transfers |
| bus_sm_rst | output | 1 | Reset strobe to bus-domain state machines |
| bus_sm_ack | input | 1 | Bus-domain state machines are idle |
| fifo_flush | output | 1 | One-cycle flush of all transmit FIFOs and the receive FIFO |
| usb_abort | output | 1 | Abort USB-side activity now |
| phy_sm_rst | output | 1 | Reset to PHY-domain state machines (phy_clk) |
| phy_sm_ack | input | 1 | PHY-domain state machines are idle (phy_clk) |
| phy_ready | output | 1 | PHY domain may be accessed (phy_clk) |

## Verification
Bus-domain results have fixed latencies. Register bits, usb_abort and mst_stop are due one bus edge after the write. bus_sm_rst is due one edge after mst_busy is sampled low. cfg_q and int_stat change one edge after the clear strobe, and a light request clears three edges after it is accepted. The bench drives inputs on falling edges and samples on the falling edge after the edge that counts, so every check falls in the exact cycle computed. PHY-side results are checked against phy_clk: phy_ready is sampled just after the second and third PHY edges that follow the fall of phy_sm_rst. The cross-domain completion of a heavy reset has no fixed cycle count. For it, the bench holds one acknowledge off for a long window and checks that the bit stays set, then polls for the clear within a bound.

// File: rtl/usb_swrst_pkg.sv
// Package: shared types and fixed register bit positions for the soft reset
// controller. The bit positions are software-visible and therefore fixed.
package usb_swrst_pkg;

    // Sequencer states, bus clock domain.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_APPLY   = 3'd2,
        ST_WAIT    = 3'd3,
        ST_RELEASE = 3'd4
    } swrst_state_e;

    // Request field positions within the register.
    localparam int HEAVY_BIT = 0;
    localparam int LIGHT_BIT = 1;
    localparam int REQ_W     = 2;

endpackage

// File: rtl/usb_swrst_sync.sv
// Module: multi-stage level synchronizer.
// Assumes: d is a slow level (held for several destination clocks);
// STAGES >= 2. Synchronous active-low reset clears every stage.
module usb_swrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Build the flop chain stage by stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the foreign-domain level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/usb_swrst_seq.sv
// Module: bus-domain reset sequencer and request register.
// Accepts a light or heavy request when idle, holds the bus master off until
// it reports no transfer in flight, issues the reset strobes, waits for the
// bus and (for heavy) PHY acknowledges, then self-clears the request bit.
// Assumes: phy_ack is already synchronized to clk; the master honours mst_stop.
module usb_swrst_seq
    import usb_swrst_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REQ_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             mst_busy,
    output logic             mst_stop,
    output logic             bus_sm_rst,
    input  logic             bus_sm_ack,
    output logic             fifo_flush,
    output logic             usb_abort,
    output logic             clr_heavy,
    output logic             clr_light,
    output logic             phy_req,
    input  logic             phy_ack
);

    localparam int IDLE_BIT = REG_W - 1;

    swrst_state_e state;
    logic         heavy_q;
    logic         light_q;
    logic         ack_seen;

    // Sequencer: request capture, drain, apply, acknowledge and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            heavy_q  <= 1'b0;
            light_q  <= 1'b0;
            ack_seen <= 1'b0;
            phy_req  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ack_seen <= 1'b0;
                    if (wr_en && wdata[HEAVY_BIT]) begin
                        heavy_q <= 1'b1;
                        state   <= ST_DRAIN;
                    end else if (wr_en && wdata[LIGHT_BIT]) begin
                        light_q <= 1'b1;
                        state   <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (!mst_busy) begin
                        state <= ST_APPLY;
                        if (heavy_q) phy_req <= 1'b1;
                    end
                end
                ST_APPLY: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (bus_sm_ack) ack_seen <= 1'b1;
                    if (heavy_q) begin
                        if ((ack_seen || bus_sm_ack) && phy_ack) begin
                            heavy_q <= 1'b0;
                            phy_req <= 1'b0;
                            state   <= ST_RELEASE;
                        end
                    end else if (bus_sm_ack) begin
                        light_q <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                ST_RELEASE: begin
                    if (!phy_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobes and holds derived from the current state.
    always_comb begin
        mst_stop   = (state == ST_DRAIN) || (state == ST_APPLY) || (state == ST_WAIT);
        bus_sm_rst = (state == ST_APPLY) || ((state == ST_WAIT) && !ack_seen);
        fifo_flush = (state == ST_APPLY) && heavy_q;
        clr_heavy  = (state == ST_APPLY) && heavy_q;
        clr_light  = (state == ST_APPLY) && light_q;
        usb_abort  = heavy_q;
    end

    // Register read image.
    always_comb begin
        rdata            = '0;
        rdata[HEAVY_BIT] = heavy_q;
        rdata[LIGHT_BIT] = light_q;
        rdata[IDLE_BIT]  = !mst_busy;
    end

    // R3
    mst_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_stop && !mst_busy) |=> !mst_busy);

    // R7
    heavy_needs_phy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(heavy_q) |-> $past(phy_ack));

    // R8
    light_needs_bus_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(light_q) |-> $past(bus_sm_ack));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (heavy_q || light_q) |=> (!$rose(heavy_q) && !$rose(light_q)));

endmodule

// File: rtl/usb_swrst_cfg.sv
// Module: configuration register and sticky interrupt status with selective
// clearing. A heavy clear keeps only the KEEP_MASK fields and empties the
// interrupt status; a light clear removes the BUS_CLR_MASK fields only.
// Assumes: clear strobes are one-cycle pulses from the sequencer; a clear
// wins over a software write in the same cycle.
module usb_swrst_cfg #(
    parameter int               CFG_W        = 16,
    parameter int               N_INT        = 4,
    parameter logic [CFG_W-1:0] KEEP_MASK    = 16'h000F,
    parameter logic [CFG_W-1:0] BUS_CLR_MASK = 16'h0FF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_heavy,
    input  logic             clr_light,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic [N_INT-1:0] int_evt,
    output logic [N_INT-1:0] int_stat
);

    // Configuration register with field-selective clears.
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_q <= '0;
        else if (clr_heavy)  cfg_q <= cfg_q & KEEP_MASK;
        else if (clr_light)  cfg_q <= cfg_q & ~BUS_CLR_MASK;
        else if (cfg_wr_en)  cfg_q <= cfg_wdata;
    end

    // Sticky interrupt status, emptied only by a heavy clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         int_stat <= '0;
        else if (clr_heavy) int_stat <= '0;
        else                int_stat <= int_stat | int_evt;
    end

    // R5
    keep_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_heavy |=> ((cfg_q & KEEP_MASK) == $past(cfg_q & KEEP_MASK)) && (int_stat == '0));

    // R4
    light_keeps_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_light |=> ((int_stat & $past(int_stat)) == $past(int_stat)));

endmodule

// File: rtl/usb_swrst_phy.sv
// Module: PHY-domain side of the heavy reset. Synchronizes the request level,
// drives the PHY state-machine reset, reports completion, and holds
// phy_ready low until SETTLE clocks after the reset is released.
// Assumes: req_lvl is a level from the bus domain held until acknowledged.
module usb_swrst_phy #(
    parameter int STAGES = 2,
    parameter int SETTLE = 3
) (
    input  logic phy_clk,
    input  logic phy_rst_n,
    input  logic req_lvl,
    output logic phy_sm_rst,
    input  logic phy_sm_ack,
    output logic phy_done,
    output logic phy_ready
);

    localparam int CNT_W = $clog2(SETTLE + 1);

    logic             req_s;
    logic [CNT_W-1:0] cnt;

    usb_swrst_sync #(.STAGES(STAGES)) i_req_sync (
        .clk   (phy_clk),
        .rst_n (phy_rst_n),
        .d     (req_lvl),
        .q     (req_s)
    );

    // Reset drive and completion flag follow the synchronized request.
    always_ff @(posedge phy_clk) begin
        if (!phy_rst_n) begin
            phy_sm_rst <= 1'b0;
            phy_done   <= 1'b0;
        end else begin
            phy_sm_rst <= req_s;
            phy_done   <= phy_sm_rst && phy_sm_ack;
        end
    end

    // Settle counter: ready returns SETTLE clocks after the reset drops.
    always_ff @(posedge phy_clk) begin
        if (!phy_rst_n) begin
            phy_ready <= 1'b1;
            cnt       <= '0;
        end else if (req_s) begin
            phy_ready <= 1'b0;
            cnt       <= '0;
        end else if (!phy_ready && !phy_sm_rst) begin
            if (cnt == CNT_W'(SETTLE - 1)) phy_ready <= 1'b1;
            else                           cnt       <= cnt + 1'b1;
        end
    end

    // R9
    ready_vs_rst_chk: assert property (@(posedge phy_clk) disable iff (!phy_rst_n)
        phy_ready |-> !phy_sm_rst);

endmodule

// File: rtl/usb_swrst_ctrl.sv
// Module: top of the self-clearing soft reset controller. Joins the bus-domain
// sequencer, the configuration/status holder, the PHY-domain side and the
// acknowledge synchronizer back into the bus domain.
// Assumes: bus_clk and phy_clk are unrelated; each domain has its own
// synchronous active-low reset.
module usb_swrst_ctrl
    import usb_swrst_pkg::*;
#(
    parameter int               REG_W        = 32,
    parameter int               CFG_W        = 16,
    parameter int               N_INT        = 4,
    parameter int               SYNC_STAGES  = 2,
    parameter int               PHY_SETTLE   = 3,
    parameter logic [CFG_W-1:0] KEEP_MASK    = 16'h000F,
    parameter logic [CFG_W-1:0] BUS_CLR_MASK = 16'h0FF0
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             phy_clk,
    input  logic             phy_rst_n,
    input  logic             reg_wr_en,
    input  logic [REQ_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic [N_INT-1:0] int_evt,
    output logic [N_INT-1:0] int_stat,
    input  logic             mst_busy,
    output logic             mst_stop,
    output logic             bus_sm_rst,
    input  logic             bus_sm_ack,
    output logic             fifo_flush,
    output logic             usb_abort,
    output logic             phy_sm_rst,
    input  logic             phy_sm_ack,
    output logic             phy_ready
);

    logic clr_heavy;
    logic clr_light;
    logic phy_req;
    logic phy_done;
    logic phy_ack_s;

    usb_swrst_seq #(.REG_W(REG_W)) i_seq (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .wr_en      (reg_wr_en),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .mst_busy   (mst_busy),
        .mst_stop   (mst_stop),
        .bus_sm_rst (bus_sm_rst),
        .bus_sm_ack (bus_sm_ack),
        .fifo_flush (fifo_flush),
        .usb_abort  (usb_abort),
        .clr_heavy  (clr_heavy),
        .clr_light  (clr_light),
        .phy_req    (phy_req),
        .phy_ack    (phy_ack_s)
    );

    usb_swrst_cfg #(
        .CFG_W        (CFG_W),
        .N_INT        (N_INT),
        .KEEP_MASK    (KEEP_MASK),
        .BUS_CLR_MASK (BUS_CLR_MASK)
    ) i_cfg (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .clr_heavy (clr_heavy),
        .clr_light (clr_light),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .int_evt   (int_evt),
        .int_stat  (int_stat)
    );

    usb_swrst_phy #(
        .STAGES (SYNC_STAGES),
        .SETTLE (PHY_SETTLE)
    ) i_phy (
        .phy_clk    (phy_clk),
        .phy_rst_n  (phy_rst_n),
        .req_lvl    (phy_req),
        .phy_sm_rst (phy_sm_rst),
        .phy_sm_ack (phy_sm_ack),
        .phy_done   (phy_done),
        .phy_ready  (phy_ready)
    );

    usb_swrst_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (phy_done),
        .q     (phy_ack_s)
    );

endmodule

// File: tb/test_usb_swrst_ctrl.sv
module test_usb_swrst_ctrl;

    logic        bus_clk = 1'b0;
    logic        phy_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        phy_rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic [3:0]  int_evt = '0;
    logic [3:0]  int_stat;
    logic        mst_busy = 1'b0;
    logic        mst_stop;
    logic        bus_sm_rst;
    logic        bus_sm_ack = 1'b0;
    logic        fifo_flush;
    logic        usb_abort;
    logic        phy_sm_rst;
    logic        phy_sm_ack = 1'b0;
    logic        phy_ready;

    logic bus_ack_en = 1'b1;
    logic phy_ack_en = 1'b1;
    int   checks = 0;
    int   fails = 0;
    int   flush_cnt = 0;
    logic [3:0] exp_int = '0;

    always #4 bus_clk = ~bus_clk;
    always #10 phy_clk = ~phy_clk;

    usb_swrst_ctrl i_usb_swrst_ctrl (.*);

    // Stand-in responders for the reset state machines.
    always @(posedge bus_clk) bus_sm_ack <= bus_sm_rst & bus_ack_en;
    always @(posedge phy_clk) phy_sm_ack <= phy_sm_rst & phy_ack_en;
    always @(posedge bus_clk) if (bus_rst_n && fifo_flush) flush_cnt <= flush_cnt + 1;

    // Vector: cfg_init[39:24] req[23:22] busy[21:18] exp_cfg[17:2] exp_flush[1] int_clr[0]
    localparam logic [39:0] VECS [7] = '{
        {16'hFFFF, 2'b10, 4'd0, 16'hF00F, 1'b0, 1'b0},
        {16'hFFFF, 2'b01, 4'd0, 16'h000F, 1'b1, 1'b1},
        {16'hA5C3, 2'b10, 4'd0, 16'hA003, 1'b0, 1'b0},
        {16'hA5C3, 2'b01, 4'd0, 16'h0003, 1'b1, 1'b1},
        {16'h1234, 2'b11, 4'd0, 16'h0004, 1'b1, 1'b1},
        {16'h5AF6, 2'b10, 4'd3, 16'h5006, 1'b0, 1'b0},
        {16'h5AF6, 2'b01, 4'd2, 16'h0006, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] d);
        @(negedge bus_clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge bus_clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic cwrite(input logic [15:0] d);
        @(negedge bus_clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        @(negedge bus_clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_evt(input logic [3:0] e);
        @(negedge bus_clk);
        int_evt = e;
        @(negedge bus_clk);
        int_evt = '0;
        exp_int = exp_int | e;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (reg_rdata[1:0] != 2'b00 && n < 400) begin
            @(negedge bus_clk);
            n++;
        end
        check(req, {30'd0, reg_rdata[1:0]}, 32'd0);
        repeat (30) @(negedge bus_clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int f0;
        repeat (10) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        phy_rst_n = 1'b1;
        @(negedge bus_clk);

        // R1 R2 reset state
        check("R1 reset rdata", reg_rdata, 32'h8000_0000);
        check("R1 reset cfg", {16'd0, cfg_q}, 32'd0);
        check("R9 reset phy_ready", {31'd0, phy_ready}, 32'd1);
        check("R1 reset strobes", {28'd0, mst_stop, bus_sm_rst, fifo_flush, usb_abort}, 32'd0);
        mst_busy = 1'b1;
        @(negedge bus_clk);
        check("R2 master busy bit31", {31'd0, reg_rdata[31]}, 32'd0);
        mst_busy = 1'b0;
        @(negedge bus_clk);
        check("R2 master idle bit31", {31'd0, reg_rdata[31]}, 32'd1);

        // Table walk: R4 R5 R11 R12
        for (int i = 0; i < 7; i++) begin
            logic [39:0] v;
            v = VECS[i];
            cwrite(v[39:24]);
            check("R12 cfg write", {16'd0, cfg_q}, {16'd0, v[39:24]});
            pulse_evt(4'b0101);
            check("R12 int sticky", {28'd0, int_stat}, {28'd0, exp_int});
            f0 = flush_cnt;
            if (v[21:18] != 0) mst_busy = 1'b1;
            bwrite(v[23:22]);
            check("R11 R1 request bits", {30'd0, reg_rdata[1:0]},
                  {30'd0, (v[22] ? 2'b01 : 2'b10)});
            repeat (int'(v[21:18])) @(negedge bus_clk);
            mst_busy = 1'b0;
            wait_done("R8 R7 self clear");
            if (v[0]) exp_int = '0;
            check(v[1] ? "R5 heavy cfg" : "R4 light cfg", {16'd0, cfg_q}, {16'd0, v[17:2]});
            check(v[1] ? "R5 heavy int" : "R4 light int", {28'd0, int_stat}, {28'd0, exp_int});
            check(v[1] ? "R5 flush once" : "R4 no flush", flush_cnt - f0, {31'd0, v[1]});
        end

        // R3 R6 drain before apply, abort at once
        cwrite(16'hBEEF);
        mst_busy = 1'b1;
        bwrite(2'b01);
        check("R6 abort while busy", {31'd0, usb_abort}, 32'd1);
        check("R3 stop asserted", {31'd0, mst_stop}, 32'd1);
        repeat (4) @(negedge bus_clk);
        check("R3 no reset while busy", {31'd0, bus_sm_rst}, 32'd0);
        check("R3 cfg untouched while busy", {16'd0, cfg_q}, 32'h0000_BEEF);
        mst_busy = 1'b0;
        @(negedge bus_clk);
        check("R3 reset after idle", {31'd0, bus_sm_rst}, 32'd1);
        wait_done("R6 heavy done");
        exp_int = '0;
        check("R6 abort released", {31'd0, usb_abort}, 32'd0);

        // R8 exact light latency
        bwrite(2'b10);
        repeat (2) @(negedge bus_clk);
        check("R8 light bit still set", {31'd0, reg_rdata[1]}, 32'd1);
        @(negedge bus_clk);
        check("R8 light bit cleared", {31'd0, reg_rdata[1]}, 32'd0);
        repeat (5) @(negedge bus_clk);

        // R4 R10 events during light reset, ignored writes
        pulse_evt(4'b0010);
        f0 = flush_cnt;
        bus_ack_en = 1'b0;
        bwrite(2'b10);
        repeat (3) @(negedge bus_clk);
        pulse_evt(4'b1000);
        check("R4 event during light reset", {28'd0, int_stat}, {28'd0, exp_int});
        bwrite(2'b01);
        check("R10 heavy ignored", {31'd0, reg_rdata[0]}, 32'd0);
        check("R10 no abort", {31'd0, usb_abort}, 32'd0);
        bus_ack_en = 1'b1;
        wait_done("R8 light done");
        check("R4 int kept", {28'd0, int_stat}, {28'd0, exp_int});
        check("R4 no flush", flush_cnt - f0, 32'd0);
        check("R10 nothing queued", {30'd0, bus_sm_rst, reg_rdata[0]}, 32'd0);

        // R7 R9 PHY acknowledge gating and ready timing
        phy_ack_en = 1'b0;
        bwrite(2'b01);
        repeat (40) @(negedge bus_clk);
        check("R7 held without phy ack", {31'd0, reg_rdata[0]}, 32'd1);
        check("R7 phy reset driven", {31'd0, phy_sm_rst}, 32'd1);
        check("R9 ready low in reset", {31'd0, phy_ready}, 32'd0);
        phy_ack_en = 1'b1;
        @(negedge phy_sm_rst);
        #1;
        check("R7 bit clear before phy release", {31'd0, reg_rdata[0]}, 32'd0);
        repeat (2) @(posedge phy_clk);
        #1;
        check("R9 ready low at edge 2", {31'd0, phy_ready}, 32'd0);
        @(posedge phy_clk);
        #1;
        check("R9 ready high at edge 3", {31'd0, phy_ready}, 32'd1);
        repeat (30) @(negedge bus_clk);

        // R7 bus acknowledge gating
        bus_ack_en = 1'b0;
        bwrite(2'b01);
        repeat (40) @(negedge bus_clk);
        check("R7 held without bus ack", {31'd0, reg_rdata[0]}, 32'd1);
        bus_ack_en = 1'b1;
        wait_done("R7 heavy done");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule